// File: doc/BRIEF.md
# Bi-phase Lighting-Bus Command Transmitter

This block drives a single two-level lighting control line with one command frame at a time. A frame holds a start bit, an 8-bit address and an 8-bit data byte. Every bit of the frame is bi-phase (Manchester) coded. After the data byte the line goes back to its high idle level and stays there, with no transitions, for a stop period. The block accepts a frame through a valid/ready handshake. It times every half bit by counting `CLKS_PER_HALFBIT` system clocks.

Once a frame has been accepted, `ready_o` stays low until the line has been idle for `GAP_HALFBITS` half-bit periods, counted from the end of the data byte. This enforces the minimum settling time between consecutive frames. The default of 22 half bits gives about 9.17 ms at a 416.67 µs half bit. A one-cycle `done_o` pulse marks the end of the stop period. Values of `GAP_HALFBITS` below 4 are raised to 4, so the gap never ends before the stop period does.

Cycle numbers below count from c = 0, which is the first clock cycle after the edge on which the frame was accepted.

Top module: `bpl_frame_tx`

## Requirements
- R1: During reset and after it, `line_o` is high, `ready_o` is high and `done_o` is low.
- R2: `addr_i` and `data_i` are captured on a clock edge where `valid_i` and `ready_o` are both high. On the next cycle (c = 0), `ready_o` is low and `line_o` is low, which is the first half of the start bit.
- R3: Each coded bit is two halves of `CLKS_PER_HALFBIT` cycles each. A '1' is low then high, and a '0' is high then low.
- R4: Bits go out in this order: the start bit (always 1), then address bits 7 down to 0, then data bits 7 down to 0. This makes 34 coded halves, covering cycles 0 to 34·CLKS_PER_HALFBIT−1.
- R5: After the data byte, `line_o` is high for 4 half bits. `done_o` is high for exactly one cycle, at c = 38·CLKS_PER_HALFBIT−1.
- R6: `line_o` stays high and `ready_o` stays low up to c = (34+GAP_HALFBITS)·CLKS_PER_HALFBIT−1. `ready_o` rises on the following cycle.
- R7: While `ready_o` is low, `valid_i`, `addr_i` and `data_i` have no effect on the line or on the next frame.
- R8: If `valid_i` is held high, a new frame is accepted in the first cycle that `ready_o` is high, so the frames follow with no extra idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | A frame is offered |
| addr_i | input | 8 | Address byte of the offered frame |
| data_i | input | 8 | Data byte of the offered frame |
| ready_o | output | 1 | High when a frame can be accepted |
| line_o | output | 1 | Bi-phase coded bus level, idles high |
| done_o | output | 1 | One-cycle pulse in the last cycle of the stop period |

## Verification
A wrong half-bit counter shows up on `line_o` within one half bit. A transition lands a cycle early or late relative to the reference model, which counts every cycle. A wrong shift register or a capture at the wrong edge inverts a half-bit level within the first few bits of the frame. An error in the frame length or the gap end moves `done_o` or the rising edge of `ready_o` by at least one cycle. Stimulus offered while the block is busy would show up as an altered later frame or a frame started early.

// File: rtl/bpl_frame_tx.sv
module bpl_frame_tx #(
  parameter int CLKS_PER_HALFBIT = 104167,
  parameter int GAP_HALFBITS     = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       line_o,
  output logic       done_o
);
  localparam int CODED = 34;
  localparam int STOPH = 4;
  localparam int GAPH  = (GAP_HALFBITS < STOPH) ? STOPH : GAP_HALFBITS;
  localparam int TOTAL = CODED + GAPH;
  localparam int CW    = $clog2(CLKS_PER_HALFBIT + 1);
  localparam int HW    = $clog2(TOTAL + 1);

  logic          busy;
  logic [CW-1:0] tick;
  logic [HW-1:0] half;
  logic [16:0]   shreg;

  wire half_end = (tick == CW'(CLKS_PER_HALFBIT - 1));
  wire coded    = (half < HW'(CODED));
  wire accept   = valid_i & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tick  <= '0;
      half  <= '0;
      shreg <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      tick  <= '0;
      half  <= '0;
      shreg <= {1'b1, addr_i, data_i};
    end else if (busy) begin
      if (half_end) begin
        tick <= '0;
        if (half == HW'(TOTAL - 1)) busy <= 1'b0;
        else                        half <= half + 1'b1;
        if (half[0]) shreg <= {shreg[15:0], 1'b0};
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  // second half carries the bit value, first half its complement
  assign line_o  = (busy && coded) ? (half[0] ? shreg[16] : ~shreg[16]) : 1'b1;
  assign done_o  = busy && (half == HW'(CODED + STOPH - 1)) && half_end;
  assign ready_o = ~busy;
endmodule

module bpl_frame_tx_chk #(
  parameter int CLKS_PER_HALFBIT = 104167,
  parameter int GAP_HALFBITS     = 22
) (
  input logic clk,
  input logic rst_n,
  input logic valid_i,
  input logic ready_o,
  input logic line_o,
  input logic done_o
);
  localparam int GAPH = (GAP_HALFBITS < 4) ? 4 : GAP_HALFBITS;
  int unsigned since_done;

  always_ff @(posedge clk) begin
    if (!rst_n)        since_done <= 0;
    else if (done_o)   since_done <= 0;
    else if (!ready_o) since_done <= since_done + 1;
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> line_o);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> (!line_o && !ready_o));
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (line_o && !ready_o));
  // R6
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (since_done == (GAPH - 4) * CLKS_PER_HALFBIT));
endmodule

bind bpl_frame_tx bpl_frame_tx_chk #(
  .CLKS_PER_HALFBIT(CLKS_PER_HALFBIT),
  .GAP_HALFBITS(GAP_HALFBITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
  .ready_o(ready_o), .line_o(line_o), .done_o(done_o)
);

// File: tb/tb_bpl_frame_tx.sv
module tb_bpl_frame_tx;
  localparam int CPH = 3;
  localparam int GAP = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] addr_i = '0, data_i = '0;
  logic ready_o, line_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit    ql[$], qd[$], qr[$];
  string qt[$];
  bit    cur_rdy = 1;

  always #2 clk = ~clk;

  bpl_frame_tx #(.CLKS_PER_HALFBIT(CPH), .GAP_HALFBITS(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .addr_i(addr_i), .data_i(data_i),
    .ready_o(ready_o), .line_o(line_o), .done_o(done_o));

  task automatic push(input bit l, input bit d, input bit r, input string t);
    ql.push_back(l); qd.push_back(d); qr.push_back(r); qt.push_back(t);
  endtask

  task automatic push_frame(input logic [7:0] a, input logic [7:0] d);
    logic [16:0] f = {1'b1, a, d};
    for (int h = 0; h < 34; h++) begin
      bit b = f[16 - h/2];
      bit lv = (h % 2 == 1) ? b : ~b;
      for (int c = 0; c < CPH; c++)
        push(lv, 1'b0, 1'b0, (h < 2) ? "R2" : ((h < 18) ? "R3" : "R4"));
    end
    for (int c = 0; c < 4*CPH; c++)
      push(1'b1, (c == 4*CPH-1), 1'b0, "R5");
    for (int c = 0; c < (GAP-4)*CPH; c++)
      push(1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic compare(input bit l, input bit d, input bit r, input string t);
    checks++;
    if (line_o !== l || done_o !== d || ready_o !== r) begin
      errors++;
      $display("FAIL %s: line/done/ready actual %b%b%b expected %b%b%b at %0t",
               t, line_o, done_o, ready_o, l, d, r, $time);
    end
  endtask

  // one cycle: check the current outputs, then drive the inputs for the next edge
  task automatic cycle(input bit v, input logic [7:0] a, input logic [7:0] d, output bit acc);
    bit l, dn, r;
    string t;
    @(negedge clk);
    if (ql.size() > 0) begin
      l = ql.pop_front(); dn = qd.pop_front(); r = qr.pop_front(); t = qt.pop_front();
    end else begin
      l = 1; dn = 0; r = 1; t = "R6";
    end
    compare(l, dn, r, t);
    cur_rdy = r;
    valid_i = v; addr_i = a; data_i = d;
    acc = v && cur_rdy;
    if (acc) push_frame(a, d);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 8'h00, acc);
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] d);
    bit acc = 0;
    while (!acc) cycle(1'b1, a, d, acc);
  endtask

  initial begin
    bit acc;
    // R1: reset state
    repeat (3) @(negedge clk);
    compare(1'b1, 1'b0, 1'b1, "R1");
    rst_n = 1'b1;
    idle(4);
    send(8'hA5, 8'h3C);
    idle(200);
    send(8'hFF, 8'h00);
    idle(200);
    send(8'h00, 8'hFF);
    // R7: offers while busy are ignored
    for (int i = 0; i < 60; i++) cycle(1'b1, 8'(i * 37), 8'(~i), acc);
    idle(200);
    // R8: back-to-back frames with valid held high
    send(8'h81, 8'h7E);
    send(8'h12, 8'hED);
    send(8'h6B, 8'h94);
    idle(250);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule